// File: doc/BRIEF.md
# GPIO port with control-bit overlays

This block is an 8-pin general-purpose I/O port that sits on a microcontroller register bus. It holds an output-data latch and a direction register, drives the pad output, output-enable and pull-up signals, and passes the pad levels through a synchronizer before software reads them back. The two upper positions of both registers are not pin state. In the data register they are write-only strobes that ask an external power controller for a low-power mode. In the direction register they are flags: one sets the serial clock phase and one enables a start-up delay.

Pin 6 is always an input, and its synchronized level goes to the serial engine. Pin 7 always drives the reference clock out. An elaboration-time watchdog option gives pin 1 to an external watchdog. In that case pin 1 is driven low only when the watchdog asserts, and a weak pull-up holds it high at all other times. The registers then have no effect on that pin.

Top module: `pinbank_ctl`

## Requirements
- R1: During and after reset both registers are zero, every pin from 0 to 5 has output-enable low, no mode request is asserted and the direction readback is 8'h00.
- R2: A data-register write (bus_addr_i = 0) with bit 7 set raises halt_req_o for exactly the one cycle after the write edge. A direction-register write never raises it.
- R3: A data-register write with bit 6 set and bit 7 clear raises idle_req_o for exactly the one cycle after the write edge.
- R4: When a single data write has both bit 6 and bit 7 set, only halt_req_o rises. The two requests are never high together.
- R5: A read at bus_addr_i = 0 returns 0 in bits 7 and 6. Bits 5..0 return the pad levels after SYNC_STAGES clock edges of synchronization.
- R6: sk_alt_phase_o equals direction-register bit 6.
- R7: startup_dly_o is direction-register bit 7 ANDed with rc_clk_sel_i, so it is 0 when rc_clk_sel_i is low.
- R8: Pin 6 never has output-enable set. Pin 7 always has output-enable set and drives clk_ref_i. serial_in_o is the synchronized level of pin 6.
- R9: For pins 0 and 2..5 (and pin 1 without the watchdog option), pad_oe_o[i] equals direction bit i and pad_out_o[i] equals data bit i.
- R10: With WDOG_OPT = 1, pin 1 has pad_pu_o[1] = 1, pad_out_o[1] = 0 and pad_oe_o[1] = !wdog_n_i, whatever register bit 1 holds. With WDOG_OPT = 0, pad_pu_o is all zero.
- R11: A read at bus_addr_i = 1 returns all 8 direction-register bits as written. The register holds its value when no direction write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 selects the data register, 1 selects the direction register |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the selected register |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables, 1 means drive |
| pad_pu_o | output | 8 | Weak pull-up enables |
| clk_ref_i | input | 1 | Clock driven out on pin 7 |
| wdog_n_i | input | 1 | Watchdog output, active low |
| rc_clk_sel_i | input | 1 | RC clock option is in use |
| halt_req_o | output | 1 | One-cycle HALT mode request |
| idle_req_o | output | 1 | One-cycle IDLE mode request |
| sk_alt_phase_o | output | 1 | Alternate serial clock phase select |
| startup_dly_o | output | 1 | Start-up delay enable after HALT |
| serial_in_o | output | 1 | Synchronized pin 6 level |

## Verification
The bench builds two instances side by side on the same stimulus. One has WDOG_OPT = 1 and SYNC_STAGES = 2. The other has WDOG_OPT = 0 and SYNC_STAGES = 3. Comparing them shows that pin 1 ignores register bit 1 only under the watchdog option, and that it follows the registers otherwise. The different synchronizer depths show the readback delay tracking the parameter, because one pad step appears one cycle apart on the two instances.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
   localparam int unsigned PORT_W     = 8;
   localparam int unsigned IO_BITS    = 6;
   localparam int unsigned HALT_BIT   = 7;
   localparam int unsigned IDLE_BIT   = 6;
   localparam int unsigned WDOG_PIN   = 1;
   localparam int unsigned INPUT_PIN  = 6;
   localparam int unsigned CLKOUT_PIN = 7;
   localparam int unsigned SYNC_W     = INPUT_PIN + 1;

   localparam logic SEL_DATA = 1'b0;
   localparam logic SEL_DIR  = 1'b1;

   typedef struct packed {
      logic halt;
      logic idle;
   } mode_req_t;
endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[0] <= '0;
      else         stage_q[0] <= async_i;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) stage_q[k] <= '0;
         else         stage_q[k] <= stage_q[k-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
   import pinbank_pkg::*;
#(
   parameter int unsigned IO_W = IO_BITS
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                wr_i,
   input  logic                addr_i,
   input  logic [PORT_W-1:0]   wdata_i,
   output logic [IO_W-1:0]     io_data_o,
   output logic [PORT_W-1:0]   dir_o,
   output mode_req_t           req_o
);
   logic [IO_W-1:0]   data_q;
   logic [PORT_W-1:0] dir_q;
   mode_req_t         req_q;
   logic              wr_data, wr_dir;

   assign wr_data = wr_i && (addr_i == SEL_DATA);
   assign wr_dir  = wr_i && (addr_i == SEL_DIR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         data_q <= '0;
         dir_q  <= '0;
         req_q  <= '0;
      end else begin
         req_q <= '0;
         if (wr_dir) dir_q <= wdata_i;
         if (wr_data) begin
            data_q     <= wdata_i[IO_W-1:0];
            req_q.halt <= wdata_i[HALT_BIT];
            req_q.idle <= wdata_i[IDLE_BIT] & ~wdata_i[HALT_BIT];
         end
      end
   end

   assign io_data_o = data_q;
   assign dir_o     = dir_q;
   assign req_o     = req_q;

   // R2: a halt request only follows a data write carrying the halt bit
   a_r2_halt_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q.halt |-> $past(wr_data && wdata_i[HALT_BIT]));
   // R3: an idle request only follows a data write with idle set and halt clear
   a_r3_idle_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_q.idle |-> $past(wr_data && wdata_i[IDLE_BIT] && !wdata_i[HALT_BIT]));
   // R4: the two requests never overlap
   a_r4_halt_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_q.halt && req_q.idle));
   // R11: direction register holds without a direction write
   a_r11_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux
   import pinbank_pkg::*;
#(
   parameter int unsigned WDOG_OPT = 0
) (
   input  logic [IO_BITS-1:0] io_data_i,
   input  logic [IO_BITS-1:0] io_dir_i,
   input  logic               clk_ref_i,
   input  logic               wdog_n_i,
   output logic [PORT_W-1:0]  pad_out_o,
   output logic [PORT_W-1:0]  pad_oe_o,
   output logic [PORT_W-1:0]  pad_pu_o
);
   logic pin1_out, pin1_oe, pin1_pu;

   if (WDOG_OPT != 0) begin : g_wdog
      logic wd_unused_bits;
      assign wd_unused_bits = io_data_i[WDOG_PIN] ^ io_dir_i[WDOG_PIN];
      assign pin1_out = 1'b0;
      assign pin1_oe  = ~wdog_n_i;
      assign pin1_pu  = 1'b1;
   end else begin : g_plain
      logic nw_unused_wdog;
      assign nw_unused_wdog = wdog_n_i;
      assign pin1_out = io_data_i[WDOG_PIN];
      assign pin1_oe  = io_dir_i[WDOG_PIN];
      assign pin1_pu  = 1'b0;
   end

   always_comb begin
      pad_out_o = '0;
      pad_oe_o  = '0;
      pad_pu_o  = '0;
      for (int i = 0; i < int'(IO_BITS); i++) begin
         pad_out_o[i] = io_data_i[i];
         pad_oe_o[i]  = io_dir_i[i];
      end
      pad_out_o[WDOG_PIN]   = pin1_out;
      pad_oe_o[WDOG_PIN]    = pin1_oe;
      pad_pu_o[WDOG_PIN]    = pin1_pu;
      pad_out_o[INPUT_PIN]  = 1'b0;
      pad_oe_o[INPUT_PIN]   = 1'b0;
      pad_out_o[CLKOUT_PIN] = clk_ref_i;
      pad_oe_o[CLKOUT_PIN]  = 1'b1;
   end
endmodule

// File: rtl/pinbank_ctl.sv
module pinbank_ctl
   import pinbank_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WDOG_OPT    = 0
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        bus_wr_i,
   input  logic        bus_addr_i,
   input  logic [7:0]  bus_wdata_i,
   output logic [7:0]  bus_rdata_o,
   input  logic [7:0]  pad_in_i,
   output logic [7:0]  pad_out_o,
   output logic [7:0]  pad_oe_o,
   output logic [7:0]  pad_pu_o,
   input  logic        clk_ref_i,
   input  logic        wdog_n_i,
   input  logic        rc_clk_sel_i,
   output logic        halt_req_o,
   output logic        idle_req_o,
   output logic        sk_alt_phase_o,
   output logic        startup_dly_o,
   output logic        serial_in_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pinbank_ctl: SYNC_STAGES must be at least 2");
   end
   if (WDOG_OPT > 1) begin : g_bad_wdog
      $error("pinbank_ctl: WDOG_OPT must be 0 or 1");
   end

   logic [IO_BITS-1:0] io_data;
   logic [PORT_W-1:0]  dir;
   mode_req_t          req;
   logic [SYNC_W-1:0]  pin_sync;
   logic               top_unused_pin7;

   assign top_unused_pin7 = pad_in_i[CLKOUT_PIN];

   pinbank_regs #(.IO_W(IO_BITS)) u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_wr_i),
      .addr_i    (bus_addr_i),
      .wdata_i   (bus_wdata_i),
      .io_data_o (io_data),
      .dir_o     (dir),
      .req_o     (req)
   );

   pinbank_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (pad_in_i[SYNC_W-1:0]),
      .sync_o  (pin_sync)
   );

   pinbank_padmux #(.WDOG_OPT(WDOG_OPT)) u_pads (
      .io_data_i (io_data),
      .io_dir_i  (dir[IO_BITS-1:0]),
      .clk_ref_i (clk_ref_i),
      .wdog_n_i  (wdog_n_i),
      .pad_out_o (pad_out_o),
      .pad_oe_o  (pad_oe_o),
      .pad_pu_o  (pad_pu_o)
   );

   assign bus_rdata_o    = (bus_addr_i == SEL_DIR) ? dir
                                                   : {2'b00, pin_sync[IO_BITS-1:0]};
   assign halt_req_o     = req.halt;
   assign idle_req_o     = req.idle;
   assign sk_alt_phase_o = dir[IDLE_BIT];
   assign startup_dly_o  = dir[HALT_BIT] & rc_clk_sel_i;
   assign serial_in_o    = pin_sync[INPUT_PIN];

   // R9: pin 0 direction follows the direction register
   a_r9_dir_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_oe_o[0] == dir[0]);
   // R8: pin 6 is never driven, pin 7 always is
   a_r8_fixed_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pad_oe_o[INPUT_PIN] && pad_oe_o[CLKOUT_PIN]);

   if (WDOG_OPT != 0) begin : g_wd_chk
      // R10: watchdog pin ignores the registers
      a_r10_wdog_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
         pad_pu_o[WDOG_PIN] && !pad_out_o[WDOG_PIN] && (pad_oe_o[WDOG_PIN] == !wdog_n_i));
   end
endmodule

// File: tb/pinbank_ctl_tb_top.sv
module pinbank_ctl_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0;
   logic addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] pad_in = '0;
   logic clk_ref = 1'b0;
   logic wdog_n = 1'b1;
   logic rc_sel = 1'b0;

   logic [7:0] rd_w, out_w, oe_w, pu_w;
   logic halt_w, idle_w, alt_w, dly_w, si_w;
   logic [7:0] rd_n, out_n, oe_n, pu_n;
   logic halt_n, idle_n, alt_n, dly_n, si_n;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pinbank_ctl #(.SYNC_STAGES(2), .WDOG_OPT(1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rd_w), .pad_in_i(pad_in),
      .pad_out_o(out_w), .pad_oe_o(oe_w), .pad_pu_o(pu_w),
      .clk_ref_i(clk_ref), .wdog_n_i(wdog_n), .rc_clk_sel_i(rc_sel),
      .halt_req_o(halt_w), .idle_req_o(idle_w), .sk_alt_phase_o(alt_w),
      .startup_dly_o(dly_w), .serial_in_o(si_w));

   pinbank_ctl #(.SYNC_STAGES(3), .WDOG_OPT(0)) dut_nw_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rd_n), .pad_in_i(pad_in),
      .pad_out_o(out_n), .pad_oe_o(oe_n), .pad_pu_o(pu_n),
      .clk_ref_i(clk_ref), .wdog_n_i(wdog_n), .rc_clk_sel_i(rc_sel),
      .halt_req_o(halt_n), .idle_req_o(idle_n), .sk_alt_phase_o(alt_n),
      .startup_dly_o(dly_n), .serial_in_o(si_n));

   // {direction, data, expected halt, expected idle}
   localparam logic [17:0] VEC [6] = '{
      {8'h3F, 8'h15, 1'b0, 1'b0},
      {8'h2A, 8'h8A, 1'b1, 1'b0},
      {8'h15, 8'h55, 1'b0, 1'b1},
      {8'hC0, 8'hC3, 1'b1, 1'b0},
      {8'h00, 8'h3F, 1'b0, 1'b0},
      {8'hFF, 8'h00, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   task automatic bus_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [7:0] dv, dd;
      // reset state, R1
      repeat (2) @(negedge clk);
      addr = 1'b1;
      chk("R1 oe in reset", {oe_w, oe_n}, {8'h80, 8'h80});
      chk("R1 dir readback in reset", {rd_w, rd_n}, 16'h0000);
      chk("R1 requests in reset", {halt_w, idle_w, halt_n, idle_n}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", oe_n, 8'h80);
      chk("R1 data pads after reset", out_n[5:0], 6'h00);

      for (int i = 0; i < 6; i++) begin
         dv = VEC[i][17:10];
         dd = VEC[i][9:2];
         rc_sel = 1'b0;
         bus_write(1'b1, dv);
         chk("R2 no request on direction write", {halt_n, idle_n, halt_w, idle_w}, 4'b0000);
         bus_write(1'b0, dd);
         chk("R2 R4 halt pulse", {halt_n, halt_w}, {VEC[i][1], VEC[i][1]});
         chk("R3 R4 idle pulse", {idle_n, idle_w}, {VEC[i][0], VEC[i][0]});
         @(negedge clk);
         chk("R2 R3 one-cycle pulse", {halt_n, idle_n, halt_w, idle_w}, 4'b0000);
         addr = 1'b1;
         #1;
         chk("R11 dir readback", {rd_n, rd_w}, {dv, dv});
         chk("R9 nowdog oe", oe_n[5:0], dv[5:0]);
         chk("R9 nowdog out", out_n[5:0], dd[5:0]);
         chk("R9 wdog other pins oe", {oe_w[5:2], oe_w[0]}, {dv[5:2], dv[0]});
         chk("R6 alt phase", {alt_n, alt_w}, {dv[6], dv[6]});
         chk("R7 delay gated off", dly_n, 1'b0);
         rc_sel = 1'b1;
         #1;
         chk("R7 delay with rc", {dly_n, dly_w}, {dv[7], dv[7]});
         chk("R8 fixed pins oe", {oe_n[7:6], oe_w[7:6]}, 4'b1010);
         clk_ref = ~clk_ref;
         #1;
         chk("R8 clock out", {out_n[7], out_w[7]}, {clk_ref, clk_ref});
         wdog_n = 1'b1;
         #1;
         chk("R10 wdog idle pin1", {pu_w, out_w[1], oe_w[1]}, {8'h02, 1'b0, 1'b0});
         wdog_n = 1'b0;
         #1;
         chk("R10 wdog active pin1", {out_w[1], oe_w[1]}, 2'b01);
         chk("R10 nowdog pin1 follows regs", {pu_n, out_n[1], oe_n[1]}, {8'h00, dd[1], dv[1]});
         wdog_n = 1'b1;
      end

      // synchronizer depth, R5 and R8
      addr = 1'b0;
      @(negedge clk);
      chk("R5 idle read", {rd_w, rd_n}, 16'h0000);
      pad_in = 8'hDA;
      @(negedge clk);
      chk("R5 one edge", {rd_w, rd_n}, 16'h0000);
      @(negedge clk);
      chk("R5 two-stage read", rd_w, 8'h1A);
      chk("R5 three-stage not yet", rd_n, 8'h00);
      chk("R8 serial in", si_w, 1'b1);
      @(negedge clk);
      chk("R5 three-stage read", rd_n, 8'h1A);
      chk("R8 serial in deep", si_n, 1'b1);

      // reset in mid-operation, R1
      bus_write(1'b1, 8'hFF);
      rst_n = 1'b0;
      #1;
      addr = 1'b1;
      #1;
      chk("R1 reset clears dir", {rd_w, rd_n}, 16'h0000);
      chk("R1 reset clears oe", oe_n, 8'h80);
      @(negedge clk);
      rst_n = 1'b1;
      finish_run();
   end
endmodule